// File: doc/BRIEF.md
# Four-Channel Legacy DMA Register Front End

This block is the programmable side of a four-channel DMA controller of the classic personal-computer kind, as a host sees it through byte-wide I/O reads and writes. Each channel holds a 16-bit base and current address, a 16-bit base and current count, a mode and a mask bit. A bank of page registers supplies the physical address bits above the 16-bit address field. A shared low/high byte pointer steers every access to a 16-bit register, so software first clears the pointer and then moves the low byte followed by the high byte.

A parameter selects a byte-wide or a word-wide controller. The word-wide variant spaces its registers twice as far apart. It holds the address as a word address and counts 16-bit words. A small transfer engine serves DMA requests one unit per cycle. It advances the address, decrements the count, signals terminal count and then either masks the channel or reloads it. This lets the register behaviour be checked end to end. Two instances on one I/O bus, one of each width at different base ports, form the usual eight-channel pair.

Top module: `legacy_dma_regs`

## Requirements
- R1: After reset every channel is masked, the byte pointer selects the low byte, and no transfer is issued even when every request line is high.
- R2: With register stride S (1 for byte-wide, 2 for word-wide), channel c's address register sits at IO_BASE + 2·c·S and its count register at that port plus S. Single-mask, mode and pointer-clear registers sit at IO_BASE + 10·S, 11·S and 12·S. The page registers of channels 0 to 3 are at ports 0x87, 0x83, 0x81, 0x82 (byte-wide) or 0x8F, 0x8B, 0x89, 0x8A (word-wide), and read back what was written.
- R3: Any write to the pointer-clear register selects the low byte. Each read or write of an address or count register then toggles the pointer, so a 16-bit register is accessed low byte first and high byte second.
- R4: A single-mask write selects the channel with data bits 1:0. Bit 2 set masks that channel and bit 2 clear unmasks it.
- R5: A mode write selects the channel with data bits 1:0. Bits 3:2 give the direction (01 = device to memory, reported as xfer_to_mem = 1; 10 = memory to device, xfer_to_mem = 0), and bit 4 set selects auto-initialize.
- R6: Each cycle the lowest-numbered channel with its request high and its mask clear gets one transfer. The reported address is the page register followed by the current address. The address then rises by one and wraps within 16 bits without carrying into the page.
- R7: A count programmed as N−1 yields exactly N transfers, with xfer_tc high only on the last. In single mode the channel then masks itself and its current count reads 0xFFFF.
- R8: In auto-initialize mode the terminal-count transfer reloads the current address and count from the base values, and the channel stays unmasked.
- R9: In the word-wide variant the reported byte address is page bits 7:1, then the 16-bit word address, then a zero bit. Each transfer advances one word.
- R10: When a host single-mask write and a single-mode terminal count hit the same channel in the same cycle, the host's mask value is what remains.
- R11: Writes to unused register indices (13 to 15), and to odd offsets in the word-wide variant, change no state and do not move the byte pointer. Reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | Host I/O write strobe, one cycle per byte |
| io_rd | input | 1 | Host I/O read strobe, one cycle per byte |
| io_addr | input | 8 | Host I/O port number |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while io_rd is high, zero otherwise |
| dreq | input | 4 | Per-channel transfer request |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| xfer_ch | output | 2 | Channel served |
| xfer_addr | output | 24 | Physical byte address of the transfer |
| xfer_to_mem | output | 1 | Direction of the served channel, 1 = device to memory |
| xfer_tc | output | 1 | This transfer is the channel's last (terminal count) |

## Verification
A host write and an engine update can fall in the same cycle on the same channel. The case that matters most is a single-mask write arriving on the very edge where a single-mode channel reaches terminal count and would mask itself. The bench holds the request of a one-unit channel high and drives an unmask write in that same cycle. It then judges the outcome at the ports. A further one-cycle request must produce a non-terminal transfer at the next address, which shows that the host's unmask won and the count wrapped to 0xFFFF.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned NCH    = 4;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned PHYS_W = REG_W + PAGE_W;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MODE_W = 6;      // stored mode bits 7:2

  // register indices (before stride scaling)
  localparam int unsigned IDX_CH_END = 8;
  localparam int unsigned IDX_MASK   = 10;
  localparam int unsigned IDX_MODE   = 11;
  localparam int unsigned IDX_CLR    = 12;

  // bit positions inside host data
  localparam int unsigned MASK_SET_BIT = 2;
  localparam int unsigned MODE_LSB     = 2;
  localparam int unsigned MODE_TOMEM   = 0; // data bit 2
  localparam int unsigned MODE_AUTO    = 2; // data bit 4

  typedef enum logic [2:0] {
    ACC_NONE, ACC_ADDR, ACC_CNT, ACC_MASK, ACC_MODE, ACC_CLR
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e       kind;
    logic [CH_W-1:0] ch;
  } acc_t;

  function automatic logic [BYTE_W-1:0] page_port(input logic word, input logic [CH_W-1:0] ch);
    logic [BYTE_W-1:0] p;
    case (ch)
      2'd0:    p = 8'h87;
      2'd1:    p = 8'h83;
      2'd2:    p = 8'h81;
      default: p = 8'h82;
    endcase
    return word ? (p | 8'h08) : p;
  endfunction
endpackage

// File: rtl/dma_decode.sv
module dma_decode import dma_pkg::*; #(
  parameter bit               WORD_MODE = 1'b0,
  parameter logic [BYTE_W-1:0] IO_BASE  = 8'h00
) (
  input  logic [BYTE_W-1:0] io_addr,
  output acc_t              acc,
  output logic [NCH-1:0]    page_hit
);
  localparam int unsigned SHIFT = WORD_MODE ? 1 : 0;

  logic [BYTE_W-1:0] off;
  logic [BYTE_W-1:0] idx;
  logic              aligned;

  assign off     = io_addr - IO_BASE;
  assign idx     = off >> SHIFT;
  assign aligned = (WORD_MODE == 1'b0) || (off[0] == 1'b0);

  always_comb begin
    acc.kind = ACC_NONE;
    acc.ch   = idx[CH_W:1];
    if (aligned) begin
      if (idx < BYTE_W'(IDX_CH_END)) begin
        acc.kind = idx[0] ? ACC_CNT : ACC_ADDR;
      end else if (idx == BYTE_W'(IDX_MASK)) begin
        acc.kind = ACC_MASK;
      end else if (idx == BYTE_W'(IDX_MODE)) begin
        acc.kind = ACC_MODE;
      end else if (idx == BYTE_W'(IDX_CLR)) begin
        acc.kind = ACC_CLR;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_page
    assign page_hit[c] = (io_addr == page_port(WORD_MODE, CH_W'(c)));
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  assign grant = req & (~req + N'(1));
  assign valid = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel import dma_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_mask,
  input  logic              mask_val,
  input  logic              wr_mode,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              grant,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  cur_cnt,
  output logic [REG_W-1:0]  base_cnt,
  output logic              masked,
  output logic              auto_en,
  output logic              to_mem,
  output logic              tc
);
  logic [REG_W-1:0]  base_addr_q, base_addr_d, addr_q, addr_d;
  logic [REG_W-1:0]  base_cnt_q, base_cnt_d, cnt_q, cnt_d;
  logic              mask_q, mask_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              en;

  assign tc = grant && (cnt_q == '0);

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    mask_d      = mask_q;
    mode_d      = mode_q;
    // engine update
    if (grant) begin
      if (cnt_q == '0 && mode_q[MODE_AUTO]) begin
        addr_d = base_addr_q;
        cnt_d  = base_cnt_q;
      end else begin
        addr_d = addr_q + REG_W'(1);
        cnt_d  = cnt_q - REG_W'(1);
        if (cnt_q == '0) mask_d = 1'b1;
      end
    end
    // host writes take precedence over the engine for the same register
    if (wr_addr) begin
      addr_d      = wr_hi ? {wdata, addr_q[BYTE_W-1:0]} : {addr_q[REG_W-1:BYTE_W], wdata};
      base_addr_d = wr_hi ? {wdata, base_addr_q[BYTE_W-1:0]} : {base_addr_q[REG_W-1:BYTE_W], wdata};
    end
    if (wr_cnt) begin
      cnt_d      = wr_hi ? {wdata, cnt_q[BYTE_W-1:0]} : {cnt_q[REG_W-1:BYTE_W], wdata};
      base_cnt_d = wr_hi ? {wdata, base_cnt_q[BYTE_W-1:0]} : {base_cnt_q[REG_W-1:BYTE_W], wdata};
    end
    if (wr_mask) mask_d = mask_val;
    if (wr_mode) mode_d = mode_val;
  end

  assign en = grant | wr_addr | wr_cnt | wr_mask | wr_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      mask_q      <= 1'b1;
      mode_q      <= '0;
    end else if (en) begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      addr_q      <= addr_d;
      cnt_q       <= cnt_d;
      mask_q      <= mask_d;
      mode_q      <= mode_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign base_cnt = base_cnt_q;
  assign masked   = mask_q;
  assign auto_en  = mode_q[MODE_AUTO];
  assign to_mem   = mode_q[MODE_TOMEM];
endmodule

// File: rtl/legacy_dma_regs.sv
module legacy_dma_regs import dma_pkg::*; #(
  parameter bit               WORD_MODE = 1'b0,
  parameter logic [BYTE_W-1:0] IO_BASE  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [BYTE_W-1:0] io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic [NCH-1:0]    dreq,
  output logic              xfer_valid,
  output logic [CH_W-1:0]   xfer_ch,
  output logic [PHYS_W-1:0] xfer_addr,
  output logic              xfer_to_mem,
  output logic              xfer_tc
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  acc_t           acc;
  logic [NCH-1:0] page_hit;

  dma_decode #(.WORD_MODE(WORD_MODE), .IO_BASE(IO_BASE)) u_dec (
    .io_addr  (io_addr),
    .acc      (acc),
    .page_hit (page_hit)
  );

  // byte pointer
  logic ptr_q, ptr_d, acc_reg;
  assign acc_reg = (acc.kind == ACC_ADDR) || (acc.kind == ACC_CNT);
  always_comb begin
    ptr_d = ptr_q;
    if (io_wr && acc.kind == ACC_CLR)     ptr_d = 1'b0;
    else if ((io_wr || io_rd) && acc_reg) ptr_d = ~ptr_q;
  end
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)             ptr_q <= 1'b0;
    else if (io_wr || io_rd)  ptr_q <= ptr_d;
  end

  logic [NCH-1:0][REG_W-1:0]  cur_addr_a, cur_cnt_a, base_cnt_a;
  logic [NCH-1:0][PAGE_W-1:0] page_q;
  logic [NCH-1:0]             mask_v, auto_v, tomem_v, tc_v, grant_v;
  logic [NCH-1:0]             addr_wr_v, cnt_wr_v, mask_wr_v, mode_wr_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign addr_wr_v[c] = io_wr && acc.kind == ACC_ADDR && acc.ch == CH_W'(c);
    assign cnt_wr_v[c]  = io_wr && acc.kind == ACC_CNT  && acc.ch == CH_W'(c);
    assign mask_wr_v[c] = io_wr && acc.kind == ACC_MASK && io_wdata[CH_W-1:0] == CH_W'(c);
    assign mode_wr_v[c] = io_wr && acc.kind == ACC_MODE && io_wdata[CH_W-1:0] == CH_W'(c);

    dma_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .wr_addr  (addr_wr_v[c]),
      .wr_cnt   (cnt_wr_v[c]),
      .wr_hi    (ptr_q),
      .wdata    (io_wdata),
      .wr_mask  (mask_wr_v[c]),
      .mask_val (io_wdata[MASK_SET_BIT]),
      .wr_mode  (mode_wr_v[c]),
      .mode_val (io_wdata[BYTE_W-1:MODE_LSB]),
      .grant    (grant_v[c]),
      .cur_addr (cur_addr_a[c]),
      .cur_cnt  (cur_cnt_a[c]),
      .base_cnt (base_cnt_a[c]),
      .masked   (mask_v[c]),
      .auto_en  (auto_v[c]),
      .to_mem   (tomem_v[c]),
      .tc       (tc_v[c])
    );

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)                  page_q[c] <= '0;
      else if (io_wr && page_hit[c]) page_q[c] <= io_wdata;
    end
  end

  dma_arb #(.N(NCH), .IW(CH_W)) u_arb (
    .req   (dreq & ~mask_v),
    .grant (grant_v),
    .valid (xfer_valid),
    .idx   (xfer_ch)
  );

  assign xfer_tc     = |tc_v;
  assign xfer_to_mem = tomem_v[xfer_ch];

  if (WORD_MODE) begin : g_word
    assign xfer_addr = {page_q[xfer_ch][PAGE_W-1:1], cur_addr_a[xfer_ch], 1'b0};
  end else begin : g_byte
    assign xfer_addr = {page_q[xfer_ch], cur_addr_a[xfer_ch]};
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (acc.kind)
        ACC_ADDR: io_rdata = ptr_q ? cur_addr_a[acc.ch][REG_W-1:BYTE_W] : cur_addr_a[acc.ch][BYTE_W-1:0];
        ACC_CNT:  io_rdata = ptr_q ? cur_cnt_a[acc.ch][REG_W-1:BYTE_W]  : cur_cnt_a[acc.ch][BYTE_W-1:0];
        default:  io_rdata = '0;
      endcase
      for (int c = 0; c < NCH; c++) begin
        if (page_hit[c]) io_rdata = page_q[c];
      end
    end
  end
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk import dma_pkg::*; (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            dreq,
  input logic [NCH-1:0]            mask_v,
  input logic [NCH-1:0]            grant_v,
  input logic [NCH-1:0]            auto_v,
  input logic [NCH-1:0]            mask_wr_v,
  input logic [NCH-1:0]            cnt_wr_v,
  input logic                      xfer_valid,
  input logic [CH_W-1:0]           xfer_ch,
  input logic                      xfer_tc,
  input logic [NCH-1:0][REG_W-1:0] cur_cnt_a,
  input logic [NCH-1:0][REG_W-1:0] base_cnt_a
);
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_v));

  assert_grant_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (dreq[xfer_ch] && !mask_v[xfer_ch]));

  assert_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (((dreq & ~mask_v) & ((NCH'(1) << xfer_ch) - NCH'(1))) == '0));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_tc && !cnt_wr_v[xfer_ch])
      |=> cur_cnt_a[$past(xfer_ch)] == $past(cur_cnt_a[xfer_ch]) - REG_W'(1));

  assert_single_tc_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_tc && !auto_v[xfer_ch] && !mask_wr_v[xfer_ch]) |=> mask_v[$past(xfer_ch)]);

  assert_auto_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_tc && auto_v[xfer_ch] && !cnt_wr_v[xfer_ch] && !mask_wr_v[xfer_ch])
      |=> (cur_cnt_a[$past(xfer_ch)] == $past(base_cnt_a[xfer_ch])) && !mask_v[$past(xfer_ch)]);
endmodule

bind legacy_dma_regs dma_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .dreq       (dreq),
  .mask_v     (mask_v),
  .grant_v    (grant_v),
  .auto_v     (auto_v),
  .mask_wr_v  (mask_wr_v),
  .cnt_wr_v   (cnt_wr_v),
  .xfer_valid (xfer_valid),
  .xfer_ch    (xfer_ch),
  .xfer_tc    (xfer_tc),
  .cur_cnt_a  (cur_cnt_a),
  .base_cnt_a (base_cnt_a)
);

// File: tb/tb_legacy_dma_regs.sv
module tb_legacy_dma_regs;
  logic        clk;
  logic        rst_n;
  logic        io_wr, io_rd;
  logic [7:0]  io_addr, io_wdata;
  logic [7:0]  rdata_b, rdata_w;
  logic [3:0]  dreq_b, dreq_w;
  logic        xv_b, xv_w, tm_b, tm_w, tc_b, tc_w;
  logic [1:0]  xc_b, xc_w;
  logic [23:0] xa_b, xa_w;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int ch; logic [23:0] addr; logic tc; logic to_mem; } exp_t;
  exp_t q_b[$];
  exp_t q_w[$];

  legacy_dma_regs #(.WORD_MODE(1'b0), .IO_BASE(8'h00)) dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .dreq(dreq_b), .xfer_valid(xv_b),
    .xfer_ch(xc_b), .xfer_addr(xa_b), .xfer_to_mem(tm_b), .xfer_tc(tc_b));

  legacy_dma_regs #(.WORD_MODE(1'b1), .IO_BASE(8'hC0)) dut_w (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(rdata_w), .dreq(dreq_w), .xfer_valid(xv_w),
    .xfer_ch(xc_w), .xfer_addr(xa_w), .xfer_to_mem(tm_w), .xfer_tc(tc_w));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #2 d = rdata_b | rdata_w;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd16(input logic [7:0] clr, input logic [7:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(clr, 8'h00);
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  // program one channel: base, stride, page port, channel, address, page, units, mode
  task automatic prog(input logic [7:0] base, input int s, input logic [7:0] pp, input int ch,
                      input logic [15:0] a, input logic [7:0] pg, input int n, input logic [7:0] mode);
    logic [15:0] c;
    c = 16'(n - 1);
    wr(base + 8'(12*s), 8'h00);
    wr(base + 8'(2*ch*s), a[7:0]);
    wr(base + 8'(2*ch*s), a[15:8]);
    wr(pp, pg);
    wr(base + 8'(2*ch*s + s), c[7:0]);
    wr(base + 8'(2*ch*s + s), c[15:8]);
    wr(base + 8'(11*s), mode | 8'(ch));
  endtask

  task automatic push_b(input int ch, input logic [23:0] a, input logic tc, input logic tm);
    exp_t e; e.ch = ch; e.addr = a; e.tc = tc; e.to_mem = tm; q_b.push_back(e);
  endtask

  task automatic push_w(input int ch, input logic [23:0] a, input logic tc, input logic tm);
    exp_t e; e.ch = ch; e.addr = a; e.tc = tc; e.to_mem = tm; q_w.push_back(e);
  endtask

  task automatic req_b(input logic [3:0] m, input int n);
    @(negedge clk); dreq_b = m;
    repeat (n) @(negedge clk);
    dreq_b = '0;
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk); #3;
    if (xv_b) begin
      if (q_b.size() == 0) begin
        checks++; failures++;
        $display("FAIL R6 unexpected byte transfer actual ch=%0d addr=%h expected none", xc_b, xa_b);
      end else begin
        exp_t e; e = q_b.pop_front();
        chk("R6 channel", 32'(xc_b), 32'(e.ch));
        chk("R6 address", 32'(xa_b), 32'(e.addr));
        chk("R7 terminal count", 32'(tc_b), 32'(e.tc));
        chk("R5 direction", 32'(tm_b), 32'(e.to_mem));
      end
    end
    if (xv_w) begin
      if (q_w.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 unexpected word transfer actual ch=%0d addr=%h expected none", xc_w, xa_w);
      end else begin
        exp_t e; e = q_w.pop_front();
        chk("R9 channel", 32'(xc_w), 32'(e.ch));
        chk("R9 address", 32'(xa_w), 32'(e.addr));
        chk("R9 terminal count", 32'(tc_w), 32'(e.tc));
        chk("R9 direction", 32'(tm_w), 32'(e.to_mem));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    rst_n = 1'b0; io_wr = 1'b0; io_rd = 1'b0; io_addr = '0; io_wdata = '0;
    dreq_b = '0; dreq_w = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all masked, no transfers (monitor flags any), pointer on low byte
    req_b(4'hF, 3);
    @(negedge clk); dreq_w = 4'hF; repeat (3) @(negedge clk); dreq_w = '0;
    wr(8'h00, 8'h34);           // no clear: pointer must already be low
    wr(8'h00, 8'h12);
    rd(8'h00, b); chk("R1 pointer low after reset", 32'(b), 32'h34);
    rd(8'h00, b); chk("R1 high byte second", 32'(b), 32'h12);

    // R3: clear restarts at the low byte mid-sequence
    wr(8'h0C, 8'h00);
    rd(8'h00, b); chk("R3 low first", 32'(b), 32'h34);
    wr(8'h0C, 8'h00);
    rd(8'h00, b); chk("R3 clear resets pointer", 32'(b), 32'h34);

    // R2 R6 R7: single mode, address wrap without page carry
    prog(8'h00, 1, 8'h83, 1, 16'hFFFE, 8'h12, 3, 8'h44);
    rd(8'h83, b); chk("R2 page port readback", 32'(b), 32'h12);
    push_b(1, 24'h12FFFE, 1'b0, 1'b1);
    push_b(1, 24'h12FFFF, 1'b0, 1'b1);
    push_b(1, 24'h120000, 1'b1, 1'b1);
    wr(8'h0A, 8'h01);
    req_b(4'h2, 5);
    chk("R7 transfer count", 32'(q_b.size()), 32'd0);
    rd16(8'h0C, 8'h03, v); chk("R7 count after tc", 32'(v), 32'hFFFF);
    rd16(8'h0C, 8'h02, v); chk("R6 address wrapped", 32'(v), 32'h0001);
    req_b(4'h2, 2);             // now masked: monitor flags any transfer

    // R6 priority, R5 direction memory-to-device
    prog(8'h00, 1, 8'h81, 2, 16'h0400, 8'h00, 2, 8'h48);
    prog(8'h00, 1, 8'h82, 3, 16'h0600, 8'h00, 2, 8'h48);
    push_b(2, 24'h000400, 1'b0, 1'b0);
    push_b(2, 24'h000401, 1'b1, 1'b0);
    push_b(3, 24'h000600, 1'b0, 1'b0);
    push_b(3, 24'h000601, 1'b1, 1'b0);
    wr(8'h0A, 8'h03);
    wr(8'h0A, 8'h02);
    req_b(4'hC, 6);
    chk("R6 priority order done", 32'(q_b.size()), 32'd0);

    // R8 auto-initialize, R4 mask/unmask
    prog(8'h00, 1, 8'h87, 0, 16'h0100, 8'h05, 2, 8'h54);
    wr(8'h0A, 8'h00);
    push_b(0, 24'h050100, 1'b0, 1'b1);
    push_b(0, 24'h050101, 1'b1, 1'b1);
    push_b(0, 24'h050100, 1'b0, 1'b1);
    push_b(0, 24'h050101, 1'b1, 1'b1);
    push_b(0, 24'h050100, 1'b0, 1'b1);
    req_b(4'h1, 5);
    chk("R8 reload transfers done", 32'(q_b.size()), 32'd0);
    rd16(8'h0C, 8'h01, v); chk("R8 count after reload", 32'(v), 32'h0000);
    rd(8'h87, b); chk("R2 page ch0", 32'(b), 32'h05);
    wr(8'h0A, 8'h04);           // mask ch0
    req_b(4'h1, 2);             // must not transfer
    wr(8'h0A, 8'h00);           // unmask ch0
    push_b(0, 24'h050101, 1'b1, 1'b1);
    req_b(4'h1, 1);
    chk("R4 unmask resumes", 32'(q_b.size()), 32'd0);
    wr(8'h0A, 8'h04);

    // R10: host unmask in the same cycle as single-mode terminal count
    prog(8'h00, 1, 8'h82, 3, 16'h2000, 8'h00, 1, 8'h44);
    wr(8'h0A, 8'h03);
    push_b(3, 24'h002000, 1'b1, 1'b1);
    @(negedge clk);
    dreq_b = 4'h8; io_wr = 1'b1; io_addr = 8'h0A; io_wdata = 8'h03;
    @(negedge clk);
    dreq_b = '0; io_wr = 1'b0;
    push_b(3, 24'h002001, 1'b0, 1'b1);   // host unmask won, count wrapped
    req_b(4'h8, 1);
    chk("R10 host mask wins", 32'(q_b.size()), 32'd0);
    wr(8'h0A, 8'h07);

    // R9 word-wide controller, stride 2 at base 0xC0
    prog(8'hC0, 2, 8'h8B, 1, 16'h2000, 8'h3A, 2, 8'h44);
    wr(8'hD4, 8'h01);
    push_w(1, 24'h3A4000, 1'b0, 1'b1);
    push_w(1, 24'h3A4002, 1'b1, 1'b1);
    @(negedge clk); dreq_w = 4'h2; repeat (4) @(negedge clk); dreq_w = '0;
    chk("R9 word transfers done", 32'(q_w.size()), 32'd0);

    // R11: unused index and odd word offset are ignored
    wr(8'hD8, 8'h00);
    wr(8'hC5, 8'h77);
    rd(8'hC5, b); chk("R11 odd offset reads zero", 32'(b), 32'h00);
    rd(8'hC4, b); chk("R11 odd write ignored, low byte", 32'(b), 32'h02);
    rd(8'hC4, b); chk("R11 pointer unmoved, high byte", 32'(b), 32'h20);
    wr(8'h0C, 8'h00);
    wr(8'h0D, 8'hFF);
    rd(8'h0E, b); chk("R11 unused index reads zero", 32'(b), 32'h00);
    rd(8'h00, b); chk("R11 ch0 addr low intact", 32'(b), 32'h00);
    rd(8'h00, b); chk("R11 ch0 addr high intact", 32'(b), 32'h01);

    repeat (3) @(negedge clk);
    chk("R6 byte scoreboard empty", 32'(q_b.size()), 32'd0);
    chk("R9 word scoreboard empty", 32'(q_w.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule